// File: doc/BRIEF.md
# Complex-Instruction Micro-Op Expander

This block sits in the decode stage of a five-stage load/store pipeline. It takes one decoded instruction per cycle and emits one micro-op per cycle. Ordinary instructions pass straight through. Three memory-touching complex instructions are broken into short, fixed sequences of simple operations that the classic pipeline can already execute. Those three are a post-increment load, a load-and-accumulate, and a memory add.

The two accumulating forms use a temporary register that software cannot name. Micro-op register fields are one bit wider than architectural register numbers. A register field with its top bit set names this temporary, T, and every architectural register appears with that top bit clear.

While a sequence is still being issued, the block raises `fetch_hold`. Fetch must then keep presenting the same instruction. An instruction counts as accepted on a rising clock edge where `in_valid` is high and `fetch_hold` is low. A downstream stall freezes both the sequence position and the registered micro-op outputs. Each micro-op appears on the outputs one clock after the edge that issues it.

The sequencing state machine has three states:
- `ST_FIRST` issues micro-op 0.
- `ST_SECOND` issues micro-op 1.
- `ST_THIRD` issues micro-op 2.

It moves only on an edge where `in_valid` is high and `down_stall` is low. The transitions are:
- `ST_FIRST` to `ST_SECOND` when the sequence length is at least 2.
- `ST_SECOND` to `ST_THIRD` when the length is 3.
- `ST_SECOND` back to `ST_FIRST` when the length is 2.
- `ST_THIRD` back to `ST_FIRST` always.

A length-1 instruction stays in `ST_FIRST`.

Top module: `uxp_expander`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted and on the first output after it, `uop_valid` is 0. The sequencer returns to `ST_FIRST`, so with no stall and no valid input `fetch_hold` is 0.
- R2: Ordinary kinds 0 to 7 pass through in one micro-op with `fetch_hold` low. The fields are:
    - op equal to the kind value (0 nop, 1 add, 2 sub, 3 add-immediate, 4 load, 5 store, 6 branch, 7 other);
    - source A = {0,rs};
    - source B = {0,rt};
    - destination = {0,rt};
    - immediate = offset.
- R3: Post-increment load (kind 8) with rt different from rs issues two micro-ops:
    - load with A={0,rs}, B=0, dst={0,rt}, imm=offset;
    - then add-immediate with A={0,rs}, B=0, dst={0,rs}, imm=4.
- R4: Post-increment load with rt equal to rs issues only the load, so the loaded value is not overwritten. `fetch_hold` stays low for it.
- R5: Load-and-accumulate (kind 9) issues two micro-ops:
    - load with A={0,rs}, B=0, dst=T, imm=offset;
    - then add with A={0,rt}, B=T, dst={0,rt}, imm=0.
- R6: Memory add (kind 10) issues three micro-ops in order:
    - load with A={0,rs}, B=0, dst=T, imm=offset;
    - add with A=T, B={0,rt}, dst=T, imm=0;
    - store with A={0,rs}, B=T, dst=0, imm=offset.
- R7: `fetch_hold` is high during every non-stalled cycle of a sequence except the cycle that issues its last micro-op. That last micro-op is the only one whose issue edge accepts the instruction.
- R8: While `down_stall` is high, `fetch_hold` is high and all registered micro-op outputs keep their values. The sequence resumes where it stopped.
- R9: An edge with `in_valid` low and no stall produces `uop_valid` low on the next output.
- R10: Kinds 11 to 15 pass through as a single nop micro-op with the fields of R2. T never appears in a sub or branch micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_kind | input | 4 | Instruction kind code |
| in_rs | input | REG_W | Base / first source register |
| in_rt | input | REG_W | Second source / destination register |
| in_off | input | IMM_W | Signed offset |
| down_stall | input | 1 | Downstream stall |
| fetch_hold | output | 1 | Fetch must re-present the same instruction |
| uop_valid | output | 1 | Micro-op valid |
| uop_op | output | 3 | Micro-op opcode |
| uop_src_a | output | REG_W+1 | Source A register (top bit selects T) |
| uop_src_b | output | REG_W+1 | Source B register |
| uop_dst | output | REG_W+1 | Destination register |
| uop_imm | output | IMM_W | Immediate |

## Verification
The properties assume that fetch keeps `in_valid` and the instruction fields unchanged in every cycle where `fetch_hold` was high. They also assume `in_valid` does not drop in the middle of a sequence. The stimulus meets both assumptions because its driver changes the instruction only after an edge at which it saw `fetch_hold` low. It otherwise leaves `in_valid` and the fields untouched. Downstream stalls come from a free-running pseudo-random pattern plus one deliberate stall placed in the middle of a memory add.

// File: rtl/uxp_pkg.sv
package uxp_pkg;

    typedef enum logic [3:0] {
        K_NOP    = 4'd0,
        K_ADD    = 4'd1,
        K_SUB    = 4'd2,
        K_ADDI   = 4'd3,
        K_LOAD   = 4'd4,
        K_STORE  = 4'd5,
        K_BRANCH = 4'd6,
        K_OTHER  = 4'd7,
        K_LDINC  = 4'd8,
        K_LDACC  = 4'd9,
        K_MEMADD = 4'd10
    } kind_e;

    typedef enum logic [2:0] {
        UOP_NOP    = 3'd0,
        UOP_ADD    = 3'd1,
        UOP_SUB    = 3'd2,
        UOP_ADDI   = 3'd3,
        UOP_LOAD   = 3'd4,
        UOP_STORE  = 3'd5,
        UOP_BRANCH = 3'd6,
        UOP_OTHER  = 3'd7
    } uop_op_e;

    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_SECOND = 2'd1,
        ST_THIRD  = 2'd2
    } seq_st_e;

    // Number of micro-ops an instruction expands into.
    function automatic logic [1:0] seq_len_f(input logic [3:0] kind, input logic same_reg);
        logic [1:0] len;
        case (kind_e'(kind))
            K_LDINC:  len = same_reg ? 2'd1 : 2'd2;
            K_LDACC:  len = 2'd2;
            K_MEMADD: len = 2'd3;
            default:  len = 2'd1;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/uxp_seq_ctrl.sv
module uxp_seq_ctrl
    import uxp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       down_stall,
    input  logic [1:0] seq_len,
    output seq_st_e    step,
    output logic       last,
    output logic       fetch_hold
);

    seq_st_e st_q;
    seq_st_e st_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_FIRST;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: advance only on an unstalled edge with a valid instruction
    always_comb begin
        st_d = st_q;
        if (in_valid && !down_stall) begin
            unique case (st_q)
                ST_FIRST:  st_d = (seq_len >= 2'd2) ? ST_SECOND : ST_FIRST;
                ST_SECOND: st_d = (seq_len == 2'd3) ? ST_THIRD : ST_FIRST;
                ST_THIRD:  st_d = ST_FIRST;
                default:   st_d = ST_FIRST;
            endcase
        end
    end

    // Outputs
    always_comb begin
        step = st_q;
        unique case (st_q)
            ST_FIRST:  last = (seq_len == 2'd1);
            ST_SECOND: last = (seq_len == 2'd2);
            ST_THIRD:  last = 1'b1;
            default:   last = 1'b1;
        endcase
        fetch_hold = down_stall | (in_valid & ~last);
    end

endmodule

// File: rtl/uxp_uop_form.sv
module uxp_uop_form
    import uxp_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int IMM_W = 16
) (
    input  logic [3:0]       kind,
    input  logic [REG_W-1:0] rs,
    input  logic [REG_W-1:0] rt,
    input  logic [IMM_W-1:0] off,
    input  seq_st_e          step,
    output logic [2:0]       op,
    output logic [REG_W:0]   src_a,
    output logic [REG_W:0]   src_b,
    output logic [REG_W:0]   dst,
    output logic [IMM_W-1:0] imm
);

    localparam int UREG_W = REG_W + 1;
    localparam logic [UREG_W-1:0] TEMP_REG = {1'b1, {REG_W{1'b0}}};
    localparam logic [UREG_W-1:0] ZERO_REG = '0;
    localparam logic [IMM_W-1:0]  STRIDE   = IMM_W'(4);

    logic [UREG_W-1:0] rs_x;
    logic [UREG_W-1:0] rt_x;

    assign rs_x = {1'b0, rs};
    assign rt_x = {1'b0, rt};

    always_comb begin
        op    = UOP_NOP;
        src_a = rs_x;
        src_b = rt_x;
        dst   = rt_x;
        imm   = off;
        case (kind_e'(kind))
            K_LDINC: begin
                if (step == ST_FIRST) begin
                    op    = UOP_LOAD;
                    src_b = ZERO_REG;
                end else begin
                    op    = UOP_ADDI;
                    src_b = ZERO_REG;
                    dst   = rs_x;
                    imm   = STRIDE;
                end
            end
            K_LDACC: begin
                if (step == ST_FIRST) begin
                    op    = UOP_LOAD;
                    src_b = ZERO_REG;
                    dst   = TEMP_REG;
                end else begin
                    op    = UOP_ADD;
                    src_a = rt_x;
                    src_b = TEMP_REG;
                    imm   = '0;
                end
            end
            K_MEMADD: begin
                unique case (step)
                    ST_FIRST: begin
                        op    = UOP_LOAD;
                        src_b = ZERO_REG;
                        dst   = TEMP_REG;
                    end
                    ST_SECOND: begin
                        op    = UOP_ADD;
                        src_a = TEMP_REG;
                        dst   = TEMP_REG;
                        imm   = '0;
                    end
                    default: begin
                        op    = UOP_STORE;
                        src_b = TEMP_REG;
                        dst   = ZERO_REG;
                    end
                endcase
            end
            default: begin
                op = kind[3] ? UOP_NOP : kind[2:0];
            end
        endcase
    end

endmodule

// File: rtl/uxp_out_reg.sv
module uxp_out_reg #(
    parameter int REG_W = 5,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             down_stall,
    input  logic             nxt_valid,
    input  logic [2:0]       nxt_op,
    input  logic [REG_W:0]   nxt_a,
    input  logic [REG_W:0]   nxt_b,
    input  logic [REG_W:0]   nxt_d,
    input  logic [IMM_W-1:0] nxt_imm,
    output logic             q_valid,
    output logic [2:0]       q_op,
    output logic [REG_W:0]   q_a,
    output logic [REG_W:0]   q_b,
    output logic [REG_W:0]   q_d,
    output logic [IMM_W-1:0] q_imm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_op    <= '0;
            q_a     <= '0;
            q_b     <= '0;
            q_d     <= '0;
            q_imm   <= '0;
        end else if (!down_stall) begin
            q_valid <= nxt_valid;
            q_op    <= nxt_op;
            q_a     <= nxt_a;
            q_b     <= nxt_b;
            q_d     <= nxt_d;
            q_imm   <= nxt_imm;
        end
    end

endmodule

// File: rtl/uxp_expander.sv
module uxp_expander
    import uxp_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       in_kind,
    input  logic [REG_W-1:0] in_rs,
    input  logic [REG_W-1:0] in_rt,
    input  logic [IMM_W-1:0] in_off,
    input  logic             down_stall,
    output logic             fetch_hold,
    output logic             uop_valid,
    output logic [2:0]       uop_op,
    output logic [REG_W:0]   uop_src_a,
    output logic [REG_W:0]   uop_src_b,
    output logic [REG_W:0]   uop_dst,
    output logic [IMM_W-1:0] uop_imm
);

    logic [1:0]       seq_len;
    seq_st_e          step;
    logic             last;
    logic [2:0]       f_op;
    logic [REG_W:0]   f_a;
    logic [REG_W:0]   f_b;
    logic [REG_W:0]   f_d;
    logic [IMM_W-1:0] f_imm;

    assign seq_len = seq_len_f(in_kind, in_rs == in_rt);

    uxp_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .down_stall (down_stall),
        .seq_len    (seq_len),
        .step       (step),
        .last       (last),
        .fetch_hold (fetch_hold)
    );

    uxp_uop_form #(.REG_W(REG_W), .IMM_W(IMM_W)) u_form (
        .kind  (in_kind),
        .rs    (in_rs),
        .rt    (in_rt),
        .off   (in_off),
        .step  (step),
        .op    (f_op),
        .src_a (f_a),
        .src_b (f_b),
        .dst   (f_d),
        .imm   (f_imm)
    );

    uxp_out_reg #(.REG_W(REG_W), .IMM_W(IMM_W)) u_oreg (
        .clk        (clk),
        .rst        (rst),
        .down_stall (down_stall),
        .nxt_valid  (in_valid),
        .nxt_op     (f_op),
        .nxt_a      (f_a),
        .nxt_b      (f_b),
        .nxt_d      (f_d),
        .nxt_imm    (f_imm),
        .q_valid    (uop_valid),
        .q_op       (uop_op),
        .q_a        (uop_src_a),
        .q_b        (uop_src_b),
        .q_d        (uop_dst),
        .q_imm      (uop_imm)
    );

endmodule

// File: rtl/uxp_expander_chk.sv
module uxp_expander_chk #(
    parameter int REG_W = 5,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [3:0]       in_kind,
    input logic [REG_W-1:0] in_rs,
    input logic [REG_W-1:0] in_rt,
    input logic [IMM_W-1:0] in_off,
    input logic             down_stall,
    input logic             fetch_hold,
    input logic             uop_valid,
    input logic [2:0]       uop_op,
    input logic [REG_W:0]   uop_src_a,
    input logic [REG_W:0]   uop_src_b,
    input logic [REG_W:0]   uop_dst,
    input logic [IMM_W-1:0] uop_imm
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always_ff @(negedge clk) begin
        if (rst_q === 1'b1) begin
            reset_valid_chk: assert (uop_valid == 1'b0);
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        down_stall |-> fetch_hold);

    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        down_stall |=> ($stable(uop_valid) && $stable(uop_op) && $stable(uop_src_a)
                        && $stable(uop_src_b) && $stable(uop_dst) && $stable(uop_imm)));

    // R9
    bubble_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !down_stall) |=> !uop_valid);

    // R2
    pass_field_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_kind[3] && !down_stall) |=>
            (uop_valid && uop_op == $past(in_kind[2:0])
             && uop_src_a == {1'b0, $past(in_rs)}
             && uop_dst == {1'b0, $past(in_rt)}
             && uop_imm == $past(in_off)));

    // R4
    self_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 4'd8 && in_rs == in_rt && !down_stall) |-> !fetch_hold);

    // R7
    accept_last_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_kind == 4'd9 || in_kind == 4'd10) && !down_stall && !fetch_hold) |=>
            (uop_op == (($past(in_kind) == 4'd9) ? 3'd1 : 3'd5)));

    // R10
    temp_private_chk: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && (uop_op == 3'd2 || uop_op == 3'd6)) |->
            (!uop_dst[REG_W] && !uop_src_a[REG_W] && !uop_src_b[REG_W]));

endmodule

bind uxp_expander uxp_expander_chk #(.REG_W(REG_W), .IMM_W(IMM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_kind    (in_kind),
    .in_rs      (in_rs),
    .in_rt      (in_rt),
    .in_off     (in_off),
    .down_stall (down_stall),
    .fetch_hold (fetch_hold),
    .uop_valid  (uop_valid),
    .uop_op     (uop_op),
    .uop_src_a  (uop_src_a),
    .uop_src_b  (uop_src_b),
    .uop_dst    (uop_dst),
    .uop_imm    (uop_imm)
);

// File: tb/sim_uxp_expander.sv
module sim_uxp_expander;

    localparam int REG_W = 5;
    localparam int IMM_W = 16;
    localparam logic [5:0] TREG = 6'h20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [3:0]       in_kind = '0;
    logic [REG_W-1:0] in_rs = '0;
    logic [REG_W-1:0] in_rt = '0;
    logic [IMM_W-1:0] in_off = '0;
    logic             down_stall = 1'b0;
    logic             fetch_hold;
    logic             uop_valid;
    logic [2:0]       uop_op;
    logic [REG_W:0]   uop_src_a;
    logic [REG_W:0]   uop_src_b;
    logic [REG_W:0]   uop_dst;
    logic [IMM_W-1:0] uop_imm;

    always #4 clk = ~clk;

    uxp_expander #(.REG_W(REG_W), .IMM_W(IMM_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_kind    (in_kind),
        .in_rs      (in_rs),
        .in_rt      (in_rt),
        .in_off     (in_off),
        .down_stall (down_stall),
        .fetch_hold (fetch_hold),
        .uop_valid  (uop_valid),
        .uop_op     (uop_op),
        .uop_src_a  (uop_src_a),
        .uop_src_b  (uop_src_b),
        .uop_dst    (uop_dst),
        .uop_imm    (uop_imm)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  a;
        logic [5:0]  b;
        logic [5:0]  d;
        logic [15:0] imm;
    } item_t;

    item_t exp_q[$];
    string req_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    logic  force_st = 1'b0;
    logic  rnd_st = 1'b0;
    logic  mon_en = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [2:0] op, input logic [5:0] a, input logic [5:0] b,
                        input logic [5:0] d, input logic [15:0] imm, input string req);
        item_t it;
        it.op = op; it.a = a; it.b = b; it.d = d; it.imm = imm;
        exp_q.push_back(it);
        req_q.push_back(req);
    endtask

    // Expected micro-ops derived from the requirements
    task automatic expect_for(input logic [3:0] k, input logic [4:0] rs, input logic [4:0] rt,
                              input logic [15:0] off);
        logic [5:0] xs;
        logic [5:0] xt;
        xs = {1'b0, rs};
        xt = {1'b0, rt};
        if (k == 4'd8) begin
            if (rs == rt) begin
                push(3'd4, xs, 6'd0, xt, off, "R4");
            end else begin
                push(3'd4, xs, 6'd0, xt, off, "R3");
                push(3'd3, xs, 6'd0, xs, 16'd4, "R3");
            end
        end else if (k == 4'd9) begin
            push(3'd4, xs, 6'd0, TREG, off, "R5");
            push(3'd1, xt, TREG, xt, 16'd0, "R5");
        end else if (k == 4'd10) begin
            push(3'd4, xs, 6'd0, TREG, off, "R6");
            push(3'd1, TREG, xt, TREG, 16'd0, "R6");
            push(3'd5, xs, TREG, 6'd0, off, "R6");
        end else if (k[3]) begin
            push(3'd0, xs, xt, xt, off, "R10");
        end else begin
            push(k[2:0], xs, xt, xt, off, "R2");
        end
    endtask

    // Driver: call at a falling edge; returns at a falling edge after acceptance
    task automatic send(input logic [3:0] k, input logic [4:0] rs, input logic [4:0] rt,
                        input logic [15:0] off);
        logic h;
        expect_for(k, rs, rt, off);
        in_valid = 1'b1;
        in_kind  = k;
        in_rs    = rs;
        in_rt    = rt;
        in_off   = off;
        forever begin
            #1;
            h = fetch_hold;
            @(posedge clk);
            @(negedge clk);
            if (!h) break;
        end
        in_valid = 1'b0;
    endtask

    // Downstream stall generator
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            down_stall = force_st | (rnd_st & lfsr[0] & lfsr[2]);
        end
    end

    // Monitor / scoreboard: a micro-op is consumed at the next edge when not stalled
    initial begin
        item_t e;
        string r;
        forever begin
            @(negedge clk);
            #2;
            if (mon_en && uop_valid && !down_stall) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected uop", {29'd0, uop_op}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(uop_op == e.op, r, "op", {29'd0, uop_op}, {29'd0, e.op});
                    check(uop_src_a == e.a && uop_src_b == e.b && uop_dst == e.d, r, "regs",
                          {14'd0, uop_src_a, uop_src_b, uop_dst}, {14'd0, e.a, e.b, e.d});
                    check(uop_imm == e.imm, r, "imm", {16'd0, uop_imm}, {16'd0, e.imm});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2:0]  s_op;
        logic [5:0]  s_d;
        logic [15:0] s_imm;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        // R1: outputs while in reset
        check(uop_valid == 1'b0, "R1", "valid in reset", {31'd0, uop_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check(uop_valid == 1'b0, "R1", "valid after reset", {31'd0, uop_valid}, 32'd0);
        check(fetch_hold == 1'b0, "R1", "hold after reset", {31'd0, fetch_hold}, 32'd0);
        mon_en = 1'b1;
        @(negedge clk);

        // R2 ordinary kinds, R10 reserved kinds
        send(4'd1, 5'd3, 5'd7, 16'h0010);
        send(4'd4, 5'd9, 5'd2, 16'hFFFC);
        send(4'd6, 5'd1, 5'd31, 16'h8000);
        send(4'd12, 5'd4, 5'd5, 16'h1234);
        // R3 / R4 post-increment
        send(4'd8, 5'd6, 5'd8, 16'h0020);
        send(4'd8, 5'd11, 5'd11, 16'h0004);
        // R5 load-and-accumulate, R6 memory add back to back
        send(4'd9, 5'd2, 5'd5, 16'h0040);
        send(4'd10, 5'd7, 5'd3, 16'hFFF0);
        send(4'd10, 5'd0, 5'd0, 16'h0000);

        // R7: hold high mid-sequence, low on the last micro-op
        in_valid = 1'b1; in_kind = 4'd10; in_rs = 5'd4; in_rt = 5'd9; in_off = 16'h0008;
        expect_for(4'd10, 5'd4, 5'd9, 16'h0008);
        #1;
        check(fetch_hold == 1'b1, "R7", "hold step0", {31'd0, fetch_hold}, 32'd1);
        @(negedge clk); #1;
        check(fetch_hold == 1'b1, "R7", "hold step1", {31'd0, fetch_hold}, 32'd1);
        @(negedge clk); #1;
        check(fetch_hold == 1'b0, "R7", "hold last", {31'd0, fetch_hold}, 32'd0);
        @(negedge clk);
        in_valid = 1'b0;

        // R9: idle cycles give no micro-ops
        repeat (2) @(negedge clk);
        #2;
        check(uop_valid == 1'b0, "R9", "idle valid", {31'd0, uop_valid}, 32'd0);
        #2;

        // R8: stall in the middle of a memory add
        @(negedge clk);
        fork
            send(4'd10, 5'd12, 5'd13, 16'h0100);
        join_none
        @(posedge clk);
        #1 force_st = 1'b1;
        @(negedge clk);
        #3;
        s_op = uop_op; s_d = uop_dst; s_imm = uop_imm;
        check(uop_valid && s_op == 3'd4 && s_d == TREG, "R8", "stalled uop",
              {16'd0, 7'd0, s_op, s_d}, {16'd0, 7'd0, 3'd4, TREG});
        repeat (3) @(negedge clk);
        #3;
        check(uop_op == s_op && uop_dst == s_d && uop_imm == s_imm && uop_valid, "R8",
              "frozen outputs", {7'd0, uop_op, uop_dst, uop_imm}, {7'd0, s_op, s_d, s_imm});
        check(fetch_hold == 1'b1, "R8", "hold during stall", {31'd0, fetch_hold}, 32'd1);
        @(posedge clk);
        #1 force_st = 1'b0;
        wait fork;

        // Mixed traffic with random downstream stalls (R2..R8, R10)
        rnd_st = 1'b1;
        for (int i = 0; i < 60; i++) begin
            logic [3:0] k;
            logic [4:0] a;
            logic [4:0] b;
            k = 4'($urandom_range(0, 15));
            a = 5'($urandom_range(0, 31));
            b = ((i % 4) == 0) ? a : 5'($urandom_range(0, 31));
            send(k, a, b, 16'($urandom));
        end
        rnd_st = 1'b0;
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R7", "leftover expected", exp_q.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule